// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind the bit-level receiver of an HDLC link and looks at the address bytes that open each frame. It decides whether the frame is meant for this station. A frame that passes has every byte after its address written to a receive FIFO write port, followed by one status byte. A frame that fails is dropped without a single FIFO write. For each decision the block also reports which address combination matched and the command/response flag it found.

The filter has three modes. In one-byte mode a single address byte is checked against two programmable values. In two-byte mode a high byte and a low byte must both match. The high byte may match a fixed group value or either of two programmable values, and the low byte must match one of two programmable values, which gives six combinations. High-only mode checks just the first byte and stores the second address byte together with the rest of the frame. Per-byte masks let selected bits be ignored, so one setting can accept a group of stations. An option takes the command/response bit of the high byte out of the comparison and reports it.

Top module: `hdlc_addr_filter`

## Requirements
- R1: In two-byte mode (cfg_mode 01, and also 11), a frame is accepted only when the first byte matches the group value (FE or FC hex), cfg_hi_a or cfg_hi_b, and the second byte matches cfg_lo_a or cfg_lo_b.
- R2: In two-byte mode, res_idx = 2*h + l. Here h is 0 for the group value, 1 for cfg_hi_a and 2 for cfg_hi_b, and l is 0 for cfg_lo_a and 1 for cfg_lo_b. When several values match, the lower h and the lower l win.
- R3: When cfg_cr_excl is 1, bit 1 of the high byte is left out of the programmable high compares and is reported as res_cr. When cfg_cr_excl is 0, bit 1 is compared and res_cr is 0 in two-byte and high-only modes.
- R4: A 1 in cfg_hi_mask or cfg_lo_mask removes that bit from the compares against the programmable high or low values. A byte matches when ((byte ^ value) & ~mask) == 0.
- R5: In one-byte mode (cfg_mode 00), the byte is compared with cfg_lo_a, giving res_idx 0 and res_cr 0 (command), and then with cfg_lo_b, giving res_idx 1 and res_cr 1 (response).
- R6: In high-only mode (cfg_mode 10), only the first byte is compared (res_idx 0, 1 or 2 for group, cfg_hi_a, cfg_hi_b). Every later byte of an accepted frame, starting with the second, is written to the FIFO.
- R7: In an accepted frame, each byte after the address is written to the FIFO in order, with fifo_wr_en high in the cycle after the byte is presented.
- R8: Two cycles after the last byte (in_eof) of an accepted frame, the block writes one status byte {4'b0000, cr, idx[2:0]}. This also applies when the frame holds nothing but its address.
- R9: A frame whose address matches nothing causes no FIFO write and reports res_accept 0.
- R10: In two-byte mode, a frame that ends on its first byte reports res_short 1 and res_accept 0, and causes no FIFO write.
- R11: in_sof inside a frame abandons that frame: no status byte is written for it, and the new byte is treated as a first address byte.
- R12: res_valid pulses for one cycle, one cycle after the byte that completes the address or ends a short frame. After reset, fifo_wr_en, res_valid and res_accept are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | DW | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_mode | input | 2 | 00 one-byte, 01/11 two-byte, 10 high-only |
| cfg_cr_excl | input | 1 | Exclude and report the command/response bit |
| cfg_hi_a | input | DW | First programmable high-byte value |
| cfg_hi_b | input | DW | Second programmable high-byte value |
| cfg_lo_a | input | DW | First programmable low-byte value |
| cfg_lo_b | input | DW | Second programmable low-byte value |
| cfg_hi_mask | input | DW | Ignore mask for high-byte compares |
| cfg_lo_mask | input | DW | Ignore mask for low-byte compares |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | DW | FIFO write data (frame byte or status) |
| res_valid | output | 1 | Address decision pulse |
| res_accept | output | 1 | Frame accepted |
| res_short | output | 1 | Frame ended inside its address |
| res_idx | output | 3 | Matched combination index |
| res_cr | output | 1 | Command/response flag |

## Verification
The bench goes after priority and encoding. If the index were computed as l*3+h, or the group value ranked below the programmable values, an FE/FC frame or a hi_b/lo_a frame would carry the wrong number in both res_idx and the status byte. The bench flips cfg_cr_excl on a high byte that differs from cfg_hi_a only in bit 1: a design that ignored the flag would accept or drop that frame wrongly. It also sends a frame that ends after its address, a frame that ends after one byte, a frame cut short by a fresh start of frame, and two frames with no gap. These catch a missing or duplicated status byte, FIFO writes for a short frame, and a status byte that collides with the next frame's data.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  typedef enum logic [1:0] {
    AM_ONE  = 2'b00,
    AM_TWO  = 2'b01,
    AM_HIGH = 2'b10,
    AM_RSV  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR2,
    ST_PASS,
    ST_DROP
  } rx_state_e;

  localparam int IDX_W = 3;

endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
  parameter int DW = 8,
  parameter int N  = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [DW-1:0]   val,
  input  logic [N*DW-1:0] cmp,
  input  logic [DW-1:0]   mask,
  output logic            any,
  output logic [SW-1:0]   sel
);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = ((val ^ cmp[i*DW +: DW]) & ~mask) == '0;
  end

  // lowest entry wins
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) sel = SW'(i);
    end
  end

  assign any = |hit;

endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
#(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  GRP_VAL = 8'hFE,
  parameter int             CR_BIT  = 1,
  localparam int            IW      = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_cr_excl,
  input  logic [DW-1:0] cfg_hi_a,
  input  logic [DW-1:0] cfg_hi_b,
  input  logic [DW-1:0] cfg_lo_a,
  input  logic [DW-1:0] cfg_lo_b,
  input  logic [DW-1:0] cfg_hi_mask,
  input  logic [DW-1:0] cfg_lo_mask,
  output logic          fwd_en,
  output logic [DW-1:0] fwd_data,
  output logic          close_frm,
  output logic [DW-1:0] stat_byte,
  output logic          res_valid,
  output logic          res_accept,
  output logic          res_short,
  output logic [IW-1:0] res_idx,
  output logic          res_cr
);

  localparam logic [DW-1:0] CR_ONLY = {{(DW-1){1'b0}}, 1'b1} << CR_BIT;

  addr_mode_e    mode;
  rx_state_e     st;
  logic          is_two;
  logic          first;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] hi_src;
  logic [DW-1:0] hi_mask_eff;
  logic          grp_hit, hi_any, hi_sel, lo_any, lo_sel, hi_ok;
  logic [1:0]    hi_code;
  logic          cr_hi;
  logic          dec_now, dec_ok, dec_cr, short_now, pass_byte;
  logic [IW-1:0] dec_idx;
  logic [IW-1:0] idx_q;
  logic          cr_q;
  logic [IW-1:0] sel_idx;
  logic          sel_cr;

  assign mode   = addr_mode_e'(cfg_mode);
  assign is_two = (mode == AM_TWO) || (mode == AM_RSV);
  assign first  = in_valid && in_sof;

  // high byte is held from the first byte in two-byte mode
  assign hi_src      = is_two ? hi_q : in_data;
  assign hi_mask_eff = cfg_hi_mask | (cfg_cr_excl ? CR_ONLY : '0);
  assign grp_hit     = (hi_src | CR_ONLY) == GRP_VAL;

  hdlc_af_match #(.DW(DW), .N(2)) i_hi_match (
    .val  (hi_src),
    .cmp  ({cfg_hi_b, cfg_hi_a}),
    .mask (hi_mask_eff),
    .any  (hi_any),
    .sel  (hi_sel)
  );

  hdlc_af_match #(.DW(DW), .N(2)) i_lo_match (
    .val  (in_data),
    .cmp  ({cfg_lo_b, cfg_lo_a}),
    .mask (cfg_lo_mask),
    .any  (lo_any),
    .sel  (lo_sel)
  );

  assign hi_ok   = grp_hit || hi_any;
  assign hi_code = grp_hit ? 2'd0 : (hi_sel ? 2'd2 : 2'd1);
  assign cr_hi   = cfg_cr_excl && hi_src[CR_BIT];

  always_comb begin
    dec_ok  = 1'b0;
    dec_idx = '0;
    dec_cr  = 1'b0;
    case (mode)
      AM_ONE: begin
        dec_ok  = lo_any;
        dec_idx = {2'b00, lo_sel};
        dec_cr  = lo_sel;
      end
      AM_HIGH: begin
        dec_ok  = hi_ok;
        dec_idx = {1'b0, hi_code};
        dec_cr  = cr_hi;
      end
      default: begin
        dec_ok  = hi_ok && lo_any;
        dec_idx = {hi_code, lo_sel};
        dec_cr  = cr_hi;
      end
    endcase
  end

  assign dec_now   = in_valid && (first ? !is_two : (st == ST_ADDR2));
  assign short_now = first && in_eof && is_two;
  assign pass_byte = in_valid && !first && (st == ST_PASS);

  assign fwd_en    = pass_byte;
  assign fwd_data  = in_data;
  assign close_frm = in_valid && in_eof && (pass_byte || (dec_now && dec_ok));

  assign sel_idx   = dec_now ? dec_idx : idx_q;
  assign sel_cr    = dec_now ? dec_cr  : cr_q;
  assign stat_byte = {{(DW-IW-1){1'b0}}, sel_cr, sel_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      hi_q       <= '0;
      idx_q      <= '0;
      cr_q       <= 1'b0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_short  <= 1'b0;
      res_idx    <= '0;
      res_cr     <= 1'b0;
    end else begin
      res_valid <= dec_now || short_now;
      if (dec_now) begin
        res_accept <= dec_ok;
        res_short  <= 1'b0;
        res_idx    <= dec_ok ? dec_idx : '0;
        res_cr     <= dec_ok ? dec_cr  : 1'b0;
        idx_q      <= dec_idx;
        cr_q       <= dec_cr;
      end else if (short_now) begin
        res_accept <= 1'b0;
        res_short  <= 1'b1;
        res_idx    <= '0;
        res_cr     <= 1'b0;
      end
      if (in_valid) begin
        if (first) begin
          hi_q <= in_data;
          if (is_two) st <= in_eof ? ST_IDLE : ST_ADDR2;
          else        st <= in_eof ? ST_IDLE : (dec_ok ? ST_PASS : ST_DROP);
        end else begin
          case (st)
            ST_ADDR2: st <= in_eof ? ST_IDLE : (dec_ok ? ST_PASS : ST_DROP);
            ST_PASS, ST_DROP: if (in_eof) st <= ST_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  // R10
  short_reject_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_short |-> !res_accept);

  // R12
  short_report_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && in_eof && is_two |=> res_valid && res_short);

  // R5
  one_byte_idx_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && mode == AM_ONE |=> res_valid && res_idx < 3'd2);

  // R6
  high_decide_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && mode == AM_HIGH |=> res_valid && !res_short);

endmodule

// File: rtl/hdlc_af_wrport.sv
module hdlc_af_wrport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_en,
  input  logic [DW-1:0] fwd_data,
  input  logic          close_frm,
  input  logic [DW-1:0] stat_byte,
  output logic          wr_en,
  output logic [DW-1:0] wr_data
);

  logic          pend_q;
  logic [DW-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      stat_q  <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      pend_q <= close_frm;
      stat_q <= stat_byte;
      if (pend_q) begin
        wr_en   <= 1'b1;
        wr_data <= stat_q;
      end else begin
        wr_en <= fwd_en;
        if (fwd_en) wr_data <= fwd_data;
      end
    end
  end

  // R8
  status_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $past(close_frm, 2) && !$past(rst, 1) && !$past(rst, 2)
      |-> wr_en && wr_data == $past(stat_byte, 2));

  // R7
  fwd_slot_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_en && !pend_q |=> wr_en && wr_data == $past(fwd_data));

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-1:0] GRP_VAL = 8'hFE,
  parameter int            CR_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_cr_excl,
  input  logic [DW-1:0] cfg_hi_a,
  input  logic [DW-1:0] cfg_hi_b,
  input  logic [DW-1:0] cfg_lo_a,
  input  logic [DW-1:0] cfg_lo_b,
  input  logic [DW-1:0] cfg_hi_mask,
  input  logic [DW-1:0] cfg_lo_mask,
  output logic          fifo_wr_en,
  output logic [DW-1:0] fifo_wr_data,
  output logic          res_valid,
  output logic          res_accept,
  output logic          res_short,
  output logic [2:0]    res_idx,
  output logic          res_cr
);

  logic          fwd_en;
  logic [DW-1:0] fwd_data;
  logic          close_frm;
  logic [DW-1:0] stat_byte;

  hdlc_af_ctrl #(.DW(DW), .GRP_VAL(GRP_VAL), .CR_BIT(CR_BIT)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .cfg_mode    (cfg_mode),
    .cfg_cr_excl (cfg_cr_excl),
    .cfg_hi_a    (cfg_hi_a),
    .cfg_hi_b    (cfg_hi_b),
    .cfg_lo_a    (cfg_lo_a),
    .cfg_lo_b    (cfg_lo_b),
    .cfg_hi_mask (cfg_hi_mask),
    .cfg_lo_mask (cfg_lo_mask),
    .fwd_en      (fwd_en),
    .fwd_data    (fwd_data),
    .close_frm   (close_frm),
    .stat_byte   (stat_byte),
    .res_valid   (res_valid),
    .res_accept  (res_accept),
    .res_short   (res_short),
    .res_idx     (res_idx),
    .res_cr      (res_cr)
  );

  hdlc_af_wrport #(.DW(DW)) i_wrport (
    .clk       (clk),
    .rst       (rst),
    .fwd_en    (fwd_en),
    .fwd_data  (fwd_data),
    .close_frm (close_frm),
    .stat_byte (stat_byte),
    .wr_en     (fifo_wr_en),
    .wr_data   (fifo_wr_data)
  );

endmodule

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cfg_mode = 2'b01;
  logic       cfg_cr_excl = 1'b0;
  logic [7:0] cfg_hi_a = 8'h10, cfg_hi_b = 8'h22, cfg_lo_a = 8'h35, cfg_lo_b = 8'h53;
  logic [7:0] cfg_hi_mask = 8'h00, cfg_lo_mask = 8'h00;
  logic       fifo_wr_en, res_valid, res_accept, res_short, res_cr;
  logic [7:0] fifo_wr_data;
  logic [2:0] res_idx;

  always #5 clk = ~clk;

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk, .rst, .in_valid, .in_data, .in_sof, .in_eof,
    .cfg_mode, .cfg_cr_excl, .cfg_hi_a, .cfg_hi_b, .cfg_lo_a, .cfg_lo_b,
    .cfg_hi_mask, .cfg_lo_mask,
    .fifo_wr_en, .fifo_wr_data, .res_valid, .res_accept, .res_short,
    .res_idx, .res_cr
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] cap [0:31];
  int         ncap = 0, nres = 0;
  logic       r_acc, r_short, r_cr;
  logic [2:0] r_idx;

  logic [7:0] fb [0:15];
  bit         fs [0:15];
  bit         fe [0:15];
  int         fn;

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_wr_en && ncap < 32) begin
        cap[ncap] = fifo_wr_data;
        ncap++;
      end
      if (res_valid) begin
        nres++;
        r_acc = res_accept; r_short = res_short; r_idx = res_idx; r_cr = res_cr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear();
    ncap = 0; nres = 0;
  endtask

  task automatic load(input int n, input logic [7:0] b0, b1, b2, b3);
    fn = n;
    fb[0] = b0; fb[1] = b1; fb[2] = b2; fb[3] = b3;
    for (int i = 0; i < 16; i++) begin fs[i] = 0; fe[i] = 0; end
    fs[0] = 1; fe[n-1] = 1;
  endtask

  task automatic send();
    for (int i = 0; i < fn; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = fb[i]; in_sof = fs[i]; in_eof = fe[i];
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'h00;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_w(input string req, input int n, input logic [7:0] e0, e1, e2, e3);
    logic [7:0] e [0:3];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(ncap == n, req, "write count", ncap, n);
    for (int i = 0; i < n && i < 4; i++)
      chk(cap[i] == e[i], req, $sformatf("write %0d", i), cap[i], e[i]);
  endtask

  task automatic expect_r(input string req, input bit acc, input logic [2:0] idx, input bit cr);
    chk(nres == 1, req, "decision count", nres, 1);
    chk(r_acc == acc, req, "accept", r_acc, acc);
    chk(r_idx == idx, req, "index", r_idx, idx);
    chk(r_cr == cr, req, "cr flag", r_cr, cr);
  endtask

  task automatic t_reset();
    chk(fifo_wr_en == 0, "R12", "reset wr_en", fifo_wr_en, 0);
    chk(res_valid == 0, "R12", "reset res_valid", res_valid, 0);
    chk(res_accept == 0, "R12", "reset res_accept", res_accept, 0);
  endtask

  // R12 and R7: exact cycle of decision, data write and status write
  task automatic t_latency();
    cfg_mode = 2'b01; clear();
    @(negedge clk); in_valid = 1; in_sof = 1; in_data = 8'h10;
    @(negedge clk); in_sof = 0; in_data = 8'h53;
    chk(res_valid == 0, "R12", "no early decision", res_valid, 0);
    @(negedge clk); in_data = 8'hA1; in_eof = 1;
    chk(res_valid == 1, "R12", "decision one cycle late", res_valid, 1);
    @(negedge clk); in_valid = 0; in_eof = 0;
    chk(res_valid == 0, "R12", "decision pulse width", res_valid, 0);
    chk(fifo_wr_en == 1 && fifo_wr_data == 8'hA1, "R7", "data slot", fifo_wr_data, 8'hA1);
    @(negedge clk);
    chk(fifo_wr_en == 1 && fifo_wr_data == 8'h03, "R8", "status slot", fifo_wr_data, 8'h03);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_two_basic();
    cfg_mode = 2'b01; cfg_cr_excl = 0;
    clear(); load(4, 8'h10, 8'h53, 8'hA1, 8'hA2); send();
    expect_r("R2", 1, 3'd3, 0); expect_w("R7", 3, 8'hA1, 8'hA2, 8'h03, 8'h00);
    clear(); load(3, 8'h22, 8'h35, 8'hC0, 8'h00); send();
    expect_r("R2", 1, 3'd4, 0); expect_w("R1", 2, 8'hC0, 8'h04, 8'h00, 8'h00);
  endtask

  task automatic t_group();
    cfg_mode = 2'b01; cfg_cr_excl = 1;
    clear(); load(3, 8'hFE, 8'h35, 8'h11, 8'h00); send();
    expect_r("R3", 1, 3'd0, 1); expect_w("R1", 2, 8'h11, 8'h08, 8'h00, 8'h00);
    clear(); load(3, 8'hFC, 8'h53, 8'h12, 8'h00); send();
    expect_r("R1", 1, 3'd1, 0); expect_w("R1", 2, 8'h12, 8'h01, 8'h00, 8'h00);
    cfg_cr_excl = 0;
    clear(); load(2, 8'hFE, 8'h35, 8'h00, 8'h00); send();
    expect_r("R3", 1, 3'd0, 0); expect_w("R8", 1, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_cr_excl();
    cfg_mode = 2'b01; cfg_cr_excl = 1;
    clear(); load(3, 8'h12, 8'h53, 8'hD0, 8'h00); send();
    expect_r("R3", 1, 3'd3, 1); expect_w("R3", 2, 8'hD0, 8'h0B, 8'h00, 8'h00);
    cfg_cr_excl = 0;
    clear(); load(3, 8'h12, 8'h53, 8'hD0, 8'h00); send();
    expect_r("R3", 0, 3'd0, 0); expect_w("R9", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_nomatch();
    cfg_mode = 2'b01;
    clear(); load(4, 8'h10, 8'h99, 8'hE0, 8'hE1); send();
    expect_r("R9", 0, 3'd0, 0); expect_w("R9", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_mask();
    cfg_mode = 2'b01; cfg_hi_mask = 8'h0F; cfg_lo_mask = 8'hF0;
    clear(); load(3, 8'h1F, 8'hA5, 8'h77, 8'h00); send();
    expect_r("R4", 1, 3'd2, 0); expect_w("R4", 2, 8'h77, 8'h02, 8'h00, 8'h00);
    cfg_hi_mask = 8'h00; cfg_lo_mask = 8'h00;
    clear(); load(3, 8'h1F, 8'hA5, 8'h77, 8'h00); send();
    expect_r("R4", 0, 3'd0, 0); expect_w("R4", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_one_byte();
    cfg_mode = 2'b00;
    clear(); load(3, 8'h53, 8'h61, 8'h62, 8'h00); send();
    expect_r("R5", 1, 3'd1, 1); expect_w("R5", 3, 8'h61, 8'h62, 8'h09, 8'h00);
    clear(); load(2, 8'h35, 8'h63, 8'h00, 8'h00); send();
    expect_r("R5", 1, 3'd0, 0); expect_w("R5", 2, 8'h63, 8'h00, 8'h00, 8'h00);
    clear(); load(2, 8'h10, 8'h64, 8'h00, 8'h00); send();
    expect_r("R9", 0, 3'd0, 0); expect_w("R9", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_high();
    cfg_mode = 2'b10; cfg_cr_excl = 0;
    clear(); load(3, 8'h22, 8'h88, 8'h71, 8'h00); send();
    expect_r("R6", 1, 3'd2, 0); expect_w("R6", 3, 8'h88, 8'h71, 8'h02, 8'h00);
    cfg_cr_excl = 1;
    clear(); load(2, 8'hFE, 8'h44, 8'h00, 8'h00); send();
    expect_r("R6", 1, 3'd0, 1); expect_w("R6", 2, 8'h44, 8'h08, 8'h00, 8'h00);
    cfg_cr_excl = 0;
  endtask

  task automatic t_short();
    cfg_mode = 2'b01;
    clear(); load(1, 8'h10, 8'h00, 8'h00, 8'h00); send();
    chk(nres == 1 && r_short == 1, "R10", "short flag", r_short, 1);
    chk(r_acc == 0, "R10", "short accept", r_acc, 0);
    expect_w("R10", 0, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_addr_only();
    cfg_mode = 2'b01;
    clear(); load(2, 8'h10, 8'h35, 8'h00, 8'h00); send();
    expect_r("R8", 1, 3'd2, 0); expect_w("R8", 1, 8'h02, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_restart();
    cfg_mode = 2'b01;
    clear(); load(7, 8'h10, 8'h53, 8'hB1, 8'h22);
    fb[4] = 8'h35; fb[5] = 8'hB2; fb[6] = 8'hB3;
    fs[3] = 1;
    send();
    chk(nres == 2, "R11", "decision count", nres, 2);
    chk(r_idx == 3'd4, "R11", "second index", r_idx, 4);
    expect_w("R11", 4, 8'hB1, 8'hB2, 8'hB3, 8'h04);
  endtask

  task automatic t_back_to_back();
    cfg_mode = 2'b01;
    clear(); load(6, 8'h10, 8'h53, 8'hA1, 8'h22);
    fb[4] = 8'h35; fb[5] = 8'hA2;
    fe[2] = 1; fs[3] = 1;
    send();
    chk(nres == 2, "R8", "decision count", nres, 2);
    expect_w("R8", 4, 8'hA1, 8'h03, 8'hA2, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_two_basic();
    t_group();
    t_cr_excl();
    t_nomatch();
    t_mask();
    t_one_byte();
    t_high();
    t_short();
    t_addr_only();
    t_restart();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule